// File: doc/BRIEF.md
# Two-Wire Bus Slave Front End with Address-Gated Clocking

This block is the bus-facing part of a small configuration device. It listens to an open-drain two-wire serial bus (SCL clock and SDA data), finds the START, repeated START and STOP conditions, and collects a 7-bit slave address followed by a direction bit. When the address matches, it acknowledges. Received bytes go to a downstream command block through a one-cycle strobe. For reads, it sends two bytes that the downstream block supplies.

Both bus lines are brought into a fast system clock domain through a synchronizer and edge detector. The system clock must run at least eight times faster than SCL. The address is checked one bit at a time. At the first bit that differs, the block stops taking SCL edges into its shift logic. It stays that way until a new START, so an idle or unrelated bus does not move its internals. SDA is driven only by a pull-down enable, and the pad turns that enable into an open-drain output.

Top module: `i2c_slave_front`

## Requirements
- R1: After reset, `sdaPullDown`, `rxValid`, `txReq` and `abortFlag` are all low and `rxData` is zero.
- R2: After a START (SDA falls while SCL is high), the block sends an ACK when the first byte holds its own 7-bit address in bits 7..1, MSB first. It sends the ACK by asserting `sdaPullDown` during the ninth SCL high period. `sdaPullDown` changes only after an SCL falling edge, a START or a STOP.
- R3: The own address is `{ADDR_HI, addrSel}`. With the default `ADDR_HI` = 6'b011010, the address is 0x34 when `addrSel` is low and 0x35 when it is high. An address that differs only in bit 0 is not acknowledged.
- R4: At the first address bit that differs, the block stops responding. It sends no ACK for the address or for any later byte and gives no `rxValid`. Its bit counter stays frozen until the next START.
- R5: The general-call address 0x00 is never acknowledged.
- R6: In a write (direction bit 0), each following 8-bit byte is received MSB first and acknowledged. One cycle after the eighth bit is taken in, `rxValid` pulses for one cycle with the byte on `rxData`.
- R7: A repeated START restarts address collection from any state, so successive writes work with or without a STOP between them.
- R8: In a read (direction bit 1), the block pulses `txReq`, loads `txData` while `txByteSel` is 0, and sends that byte MSB first. If the master ACKs it (SDA low on the ninth clock), the block loads and sends `txData` with `txByteSel` = 1.
- R9: If the master NACKs a sent byte (SDA high on the ninth clock), the block releases SDA. It then drives nothing and requests nothing until the next START.
- R10: A STOP (SDA rises while SCL is high) returns the block to idle from any state. `abortFlag` pulses for one cycle if a STOP or START arrives while the current byte has between 1 and 7 bits transferred. It does not pulse when the STOP or START falls between bytes.
- R11: A STOP that occurs in the same SCL high period as the START before it is ignored, and the transfer continues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rstN | input | 1 | Active-low asynchronous reset |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| addrSel | input | 1 | Sets bit 0 of the slave address |
| sdaPullDown | output | 1 | Enable for the open-drain SDA pull-down |
| rxValid | output | 1 | One-cycle strobe: a received byte is on rxData |
| rxData | output | DATA_W | Last received byte |
| txReq | output | 1 | One-cycle strobe: txData was loaded for sending |
| txByteSel | output | 1 | Which read byte txData must present (0 first, 1 second) |
| txData | input | DATA_W | Byte to send, selected by txByteSel |
| abortFlag | output | 1 | One-cycle strobe: a byte was cut short by STOP or START |

## Verification
The assertions assume a bus that follows the protocol:
- SCL is slow enough that every level lasts several system clocks.
- SDA changes only while SCL is low, except at START and STOP.
- `addrSel` is static.

The stimulus holds SCL low and high for at least eleven cycles each. It changes the master's SDA three cycles after each SCL falling edge, which gives the synchronizer time to settle. It samples the line in the middle of each high period. The one deliberate exception is the early-STOP case, where SDA rises during the START's own high period.

// File: rtl/i2c_front_pkg.sv
package i2c_front_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WRITE,
    ST_WR_ACK,
    ST_READ,
    ST_RD_ACK
  } frontState_t;

  // bus events in the system clock domain
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic startDet;
    logic stopDet;
  } busEvent_t;

  // strobes from control to datapath
  typedef struct packed {
    logic restart;
    logic sample;
    logic shiftRx;
    logic shiftTx;
    logic loadTx;
    logic drop;
  } dpStrobe_t;

endpackage

// File: rtl/i2c_front_sync.sv
module i2c_front_sync
  import i2c_front_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      sclIn,
  input  logic      sdaIn,
  output busEvent_t busEv,
  output logic      sdaNow
);

  logic [SYNC_STAGES-1:0] sclPipe;
  logic [SYNC_STAGES-1:0] sdaPipe;
  logic sclPrev, sdaPrev, sclS, sdaS;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= sclIn;
          sdaPipe <= sdaIn;
        end
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
    end
  endgenerate

  assign sclS = sclPipe[SYNC_STAGES-1];
  assign sdaS = sdaPipe[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclPrev <= sclS;
      sdaPrev <= sdaS;
    end
  end

  assign busEv.sclRise  = sclS & ~sclPrev;
  assign busEv.sclFall  = ~sclS & sclPrev;
  assign busEv.startDet = sclS & sclPrev & sdaPrev & ~sdaS;
  assign busEv.stopDet  = sclS & sclPrev & ~sdaPrev & sdaS;
  assign sdaNow         = sdaS;

endmodule

// File: rtl/i2c_front_datapath.sv
module i2c_front_datapath
  import i2c_front_pkg::*;
#(
  parameter int              DATA_W  = 8,
  parameter int              ADDR_W  = 7,
  parameter int              CNT_W   = 4,
  parameter logic [ADDR_W-2:0] ADDR_HI = 6'b011010
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic              sdaNow,
  input  logic              addrSel,
  input  logic [DATA_W-1:0] txData,
  output logic [DATA_W-1:0] rxData,
  output logic              sampledBit,
  output logic              bitPending,
  output logic              lastBit,
  output logic              midByte,
  output logic              addrBitOk,
  output logic              txHead,
  output logic              txNext,
  output logic [CNT_W-1:0]  bitCount
);

  logic [CNT_W-1:0]  bitCnt;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] txShift;
  logic [ADDR_W-1:0] ownAddr;
  logic              generalCall;
  logic              expBit;

  assign ownAddr     = {ADDR_HI, addrSel};
  assign generalCall = (ownAddr == '0);

  // expected address bit for the current position, MSB first
  always_comb begin
    expBit = 1'b0;
    for (int i = 0; i < ADDR_W; i++) begin
      if (bitCnt == CNT_W'(ADDR_W - 1 - i)) expBit = ownAddr[i];
    end
  end

  assign addrBitOk = (bitCnt >= CNT_W'(ADDR_W)) ||
                     (!generalCall && (sampledBit == expBit));
  assign lastBit   = (bitCnt == CNT_W'(DATA_W - 1));
  assign midByte   = (bitCnt != '0);
  assign rxData    = rxShift;
  assign txHead    = txData[DATA_W-1];
  assign txNext    = txShift[DATA_W-2];
  assign bitCount  = bitCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt     <= '0;
      bitPending <= 1'b0;
      sampledBit <= 1'b0;
      rxShift    <= '0;
      txShift    <= '0;
    end else if (strobe.restart) begin
      bitCnt     <= '0;
      bitPending <= 1'b0;
    end else begin
      if (strobe.sample) begin
        sampledBit <= sdaNow;
        bitPending <= 1'b1;
      end
      if (strobe.shiftRx) begin
        rxShift    <= {rxShift[DATA_W-2:0], sampledBit};
        bitPending <= 1'b0;
        bitCnt     <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strobe.shiftTx) begin
        txShift    <= txShift << 1;
        bitPending <= 1'b0;
        bitCnt     <= lastBit ? '0 : bitCnt + 1'b1;
      end
      if (strobe.drop) bitPending <= 1'b0;
      if (strobe.loadTx) begin
        txShift <= txData;
        bitCnt  <= '0;
      end
    end
  end

endmodule

// File: rtl/i2c_front_ctrl.sv
module i2c_front_ctrl
  import i2c_front_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  busEvent_t   busEv,
  input  logic        bitPending,
  input  logic        sampledBit,
  input  logic        lastBit,
  input  logic        midByte,
  input  logic        addrBitOk,
  input  logic        txHead,
  input  logic        txNext,
  output dpStrobe_t   strobe,
  output frontState_t state,
  output logic        sdaPullDown,
  output logic        rxValid,
  output logic        txReq,
  output logic        txByteSel,
  output logic        abortFlag
);

  logic rwBit, finalByte, startHigh;
  logic selected, fallWork, stopOk;

  assign selected = (state != ST_IDLE);
  assign fallWork = busEv.sclFall && bitPending && selected;
  assign stopOk   = busEv.stopDet && !startHigh;

  always_comb begin
    strobe        = '0;
    strobe.sample = busEv.sclRise && selected;
    if (busEv.startDet) begin
      strobe.restart = 1'b1;
    end else if (fallWork) begin
      case (state)
        ST_ADDR, ST_WRITE: strobe.shiftRx = 1'b1;
        ST_READ:           strobe.shiftTx = 1'b1;
        ST_ADDR_ACK: begin
          strobe.drop   = 1'b1;
          strobe.loadTx = rwBit;
        end
        ST_WR_ACK:         strobe.drop = 1'b1;
        ST_RD_ACK: begin
          strobe.drop   = 1'b1;
          strobe.loadTx = !sampledBit && !finalByte;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      sdaPullDown <= 1'b0;
      rxValid     <= 1'b0;
      txReq       <= 1'b0;
      txByteSel   <= 1'b0;
      abortFlag   <= 1'b0;
      rwBit       <= 1'b0;
      finalByte   <= 1'b0;
      startHigh   <= 1'b0;
    end else begin
      rxValid   <= 1'b0;
      txReq     <= 1'b0;
      abortFlag <= 1'b0;

      if (busEv.startDet)     startHigh <= 1'b1;
      else if (busEv.sclFall) startHigh <= 1'b0;

      if (busEv.startDet) begin
        abortFlag   <= selected && midByte;
        state       <= ST_ADDR;
        sdaPullDown <= 1'b0;
      end else if (stopOk) begin
        abortFlag   <= selected && midByte;
        state       <= ST_IDLE;
        sdaPullDown <= 1'b0;
      end else if (fallWork) begin
        case (state)
          ST_ADDR: begin
            if (!addrBitOk) begin
              state <= ST_IDLE;
            end else if (lastBit) begin
              rwBit       <= sampledBit;
              txByteSel   <= 1'b0;
              finalByte   <= 1'b0;
              state       <= ST_ADDR_ACK;
              sdaPullDown <= 1'b1;
            end
          end
          ST_WRITE: begin
            if (lastBit) begin
              rxValid     <= 1'b1;
              state       <= ST_WR_ACK;
              sdaPullDown <= 1'b1;
            end
          end
          ST_ADDR_ACK: begin
            if (rwBit) begin
              state       <= ST_READ;
              txReq       <= 1'b1;
              sdaPullDown <= ~txHead;
            end else begin
              state       <= ST_WRITE;
              sdaPullDown <= 1'b0;
            end
          end
          ST_WR_ACK: begin
            state       <= ST_WRITE;
            sdaPullDown <= 1'b0;
          end
          ST_READ: begin
            if (lastBit) begin
              state       <= ST_RD_ACK;
              sdaPullDown <= 1'b0;
              finalByte   <= txByteSel;
              txByteSel   <= 1'b1;
            end else begin
              sdaPullDown <= ~txNext;
            end
          end
          ST_RD_ACK: begin
            if (!sampledBit && !finalByte) begin
              state       <= ST_READ;
              txReq       <= 1'b1;
              sdaPullDown <= ~txHead;
            end else begin
              state       <= ST_IDLE;
              sdaPullDown <= 1'b0;
            end
          end
          default: state <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_slave_front.sv
module i2c_slave_front
  import i2c_front_pkg::*;
#(
  parameter int                DATA_W      = 8,
  parameter int                ADDR_W      = 7,
  parameter logic [ADDR_W-2:0] ADDR_HI     = 6'b011010,
  parameter int                SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclIn,
  input  logic              sdaIn,
  input  logic              addrSel,
  output logic              sdaPullDown,
  output logic              rxValid,
  output logic [DATA_W-1:0] rxData,
  output logic              txReq,
  output logic              txByteSel,
  input  logic [DATA_W-1:0] txData,
  output logic              abortFlag
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  busEvent_t   busEv;
  dpStrobe_t   strobe;
  frontState_t frontState;
  logic        sdaNow, sampledBit, bitPending, lastBit, midByte;
  logic        addrBitOk, txHead, txNext;
  logic [CNT_W-1:0] bitCount;

  i2c_front_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .busEv(busEv), .sdaNow(sdaNow)
  );

  i2c_front_datapath #(
    .DATA_W(DATA_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W), .ADDR_HI(ADDR_HI)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .sdaNow(sdaNow),
    .addrSel(addrSel), .txData(txData), .rxData(rxData),
    .sampledBit(sampledBit), .bitPending(bitPending), .lastBit(lastBit),
    .midByte(midByte), .addrBitOk(addrBitOk), .txHead(txHead),
    .txNext(txNext), .bitCount(bitCount)
  );

  i2c_front_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busEv(busEv), .bitPending(bitPending),
    .sampledBit(sampledBit), .lastBit(lastBit), .midByte(midByte),
    .addrBitOk(addrBitOk), .txHead(txHead), .txNext(txNext),
    .strobe(strobe), .state(frontState), .sdaPullDown(sdaPullDown),
    .rxValid(rxValid), .txReq(txReq), .txByteSel(txByteSel),
    .abortFlag(abortFlag)
  );

endmodule

// File: rtl/i2c_front_checker.sv
module i2c_front_checker
  import i2c_front_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input frontState_t      frontState,
  input logic             sclFall,
  input logic             startDet,
  input logic             stopDet,
  input logic [CNT_W-1:0] bitCount,
  input logic             sdaPullDown,
  input logic             rxValid,
  input logic             txReq,
  input logic             abortFlag
);

  AST_PD_ONLY_SELECTED: assert property (@(posedge clk) disable iff (!rstN)
    sdaPullDown |-> (frontState != ST_IDLE && frontState != ST_ADDR && frontState != ST_WRITE)); // R4

  AST_GATED_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    (frontState == ST_IDLE && $past(frontState) == ST_IDLE) |-> $stable(bitCount)); // R4

  AST_RX_WITH_ACK: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> (frontState == ST_WR_ACK && sdaPullDown)); // R6

  AST_TXREQ_IN_READ: assert property (@(posedge clk) disable iff (!rstN)
    txReq |-> frontState == ST_READ); // R8

  AST_ABORT_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    abortFlag |-> $past(startDet || stopDet)); // R10

  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (sdaPullDown != $past(sdaPullDown)) |-> $past(sclFall || startDet || stopDet)); // R2

endmodule

bind i2c_slave_front i2c_front_checker #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .frontState(frontState),
  .sclFall(busEv.sclFall), .startDet(busEv.startDet), .stopDet(busEv.stopDet),
  .bitCount(bitCount), .sdaPullDown(sdaPullDown), .rxValid(rxValid),
  .txReq(txReq), .abortFlag(abortFlag)
);

// File: tb/i2c_slave_front_bench.sv
module i2c_slave_front_bench;

  localparam logic [7:0] WR0 = 8'h68;  // 0x34 write
  localparam logic [7:0] RD0 = 8'h69;  // 0x34 read
  localparam logic [7:0] WR1 = 8'h6A;  // 0x35 write
  localparam logic [7:0] TXB0 = 8'hC3;
  localparam logic [7:0] TXB1 = 8'h5A;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclM = 1'b1;
  logic sdaM = 1'b1;
  logic addrSel = 1'b0;
  logic sdaPullDown, rxValid, txReq, txByteSel, abortFlag;
  logic [7:0] rxData, txData;
  logic sdaLine;

  int checks = 0;
  int fails = 0;
  int rxCount = 0;
  int txCount = 0;
  int abortCount = 0;
  logic [7:0] lastRx = 8'h00;

  always #2 clk = ~clk;

  assign sdaLine = sdaM & ~sdaPullDown;
  assign txData  = txByteSel ? TXB1 : TXB0;

  i2c_slave_front u_i2c_slave_front (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaLine), .addrSel(addrSel),
    .sdaPullDown(sdaPullDown), .rxValid(rxValid), .rxData(rxData),
    .txReq(txReq), .txByteSel(txByteSel), .txData(txData), .abortFlag(abortFlag)
  );

  always @(negedge clk) begin
    if (rstN) begin
      if (rxValid) begin
        rxCount++;
        lastRx = rxData;
      end
      if (txReq) txCount++;
      if (abortFlag) abortCount++;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busStart();
    if (!sclM) begin
      waitN(3); sdaM = 1'b1; waitN(6); sclM = 1'b1; waitN(8);
    end
    sdaM = 1'b0; waitN(8);
    sclM = 1'b0;
  endtask

  task automatic busStop();
    waitN(3); sdaM = 1'b0; waitN(6);
    sclM = 1'b1; waitN(8);
    sdaM = 1'b1; waitN(16);
  endtask

  task automatic clockBit(input logic b, output logic seen);
    waitN(3); sdaM = b; waitN(8);
    sclM = 1'b1; waitN(5);
    seen = sdaLine; waitN(6);
    sclM = 1'b0;
  endtask

  task automatic sendByte(input logic [7:0] d, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clockBit(d[i], s);
    clockBit(1'b1, s);
    acked = !s;
  endtask

  task automatic readByte(input logic giveAck, output logic [7:0] d);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clockBit(1'b1, s);
      d[i] = s;
    end
    clockBit(!giveAck, s);
  endtask

  task automatic testReset();
    check("R1 sdaPullDown after reset", sdaPullDown, 0);
    check("R1 rxValid after reset", rxValid, 0);
    check("R1 txReq after reset", txReq, 0);
    check("R1 abortFlag after reset", abortFlag, 0);
    check("R1 rxData after reset", rxData, 0);
  endtask

  task automatic testWrite();
    logic a;
    int rx0 = rxCount;
    int ab0 = abortCount;
    busStart();
    sendByte(WR0, a); check("R2 address ack", a, 1);
    sendByte(8'hA5, a); check("R6 data ack", a, 1);
    check("R6 first byte", lastRx, 8'hA5);
    sendByte(8'h3C, a); check("R6 second data ack", a, 1);
    check("R6 second byte", lastRx, 8'h3C);
    check("R6 strobe count", rxCount - rx0, 2);
    busStop();
    check("R10 no abort at byte boundary", abortCount - ab0, 0);
  endtask

  task automatic testAddrSel();
    logic a;
    addrSel = 1'b1; waitN(4);
    busStart(); sendByte(WR0, a); busStop();
    check("R3 low address refused when addrSel high", a, 0);
    busStart(); sendByte(WR1, a); busStop();
    check("R3 high address acked when addrSel high", a, 1);
    addrSel = 1'b0; waitN(4);
  endtask

  task automatic testMismatch();
    logic a;
    int rx0 = rxCount;
    busStart();
    sendByte(8'h70, a); check("R4 mismatched address not acked", a, 0);
    sendByte(8'h11, a); check("R4 later byte not acked", a, 0);
    check("R4 no rxValid while gated", rxCount - rx0, 0);
    busStop();
  endtask

  task automatic testGeneralCall();
    logic a;
    busStart();
    sendByte(8'h00, a); check("R5 general call not acked", a, 0);
    sendByte(8'h22, a); check("R5 data after general call not acked", a, 0);
    busStop();
  endtask

  task automatic testRestartWrites();
    logic a;
    int rx0 = rxCount;
    busStart();
    sendByte(WR0, a); sendByte(8'h12, a);
    busStart();
    sendByte(WR0, a); check("R7 address ack after repeated START", a, 1);
    sendByte(8'h34, a); check("R7 data ack after repeated START", a, 1);
    check("R7 byte after repeated START", lastRx, 8'h34);
    check("R7 strobe count", rxCount - rx0, 2);
    busStop();
  endtask

  task automatic testRead();
    logic a;
    logic [7:0] d;
    int tx0 = txCount;
    busStart();
    sendByte(WR0, a); sendByte(8'h40, a);
    busStart();
    sendByte(RD0, a); check("R8 read address ack", a, 1);
    readByte(1'b1, d); check("R8 first read byte", d, TXB0);
    readByte(1'b0, d); check("R8 second read byte", d, TXB1);
    check("R8 txReq count", txCount - tx0, 2);
    busStop();
  endtask

  task automatic testNack();
    logic a;
    logic [7:0] d;
    int tx0 = txCount;
    busStart();
    sendByte(RD0, a);
    readByte(1'b0, d); check("R9 byte before NACK", d, TXB0);
    readByte(1'b0, d); check("R9 line released after NACK", d, 8'hFF);
    check("R9 no further txReq", txCount - tx0, 1);
    busStop();
  endtask

  task automatic testAbort();
    logic a, s;
    int rx0 = rxCount;
    int ab0 = abortCount;
    busStart();
    sendByte(WR0, a);
    clockBit(1'b1, s); clockBit(1'b0, s); clockBit(1'b1, s);
    busStop();
    check("R10 abort on STOP mid byte", abortCount - ab0, 1);
    check("R10 no rxValid for cut byte", rxCount - rx0, 0);
    busStart(); sendByte(8'h7E, a); check("R10 idle after STOP refuses bad address", a, 0);
    busStop();
  endtask

  task automatic testEarlyStop();
    logic a;
    sdaM = 1'b0; waitN(8);
    sdaM = 1'b1; waitN(8);
    sclM = 1'b0;
    sendByte(WR0, a); check("R11 early STOP ignored, address acked", a, 1);
    sendByte(8'h77, a); check("R11 data acked", a, 1);
    check("R11 data received", lastRx, 8'h77);
    busStop();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    waitN(5);
    rstN = 1'b1;
    waitN(5);
    testReset();
    testWrite();
    testAddrSel();
    testMismatch();
    testGeneralCall();
    testRestartWrites();
    testRead();
    testNack();
    testAbort();
    testEarlyStop();
    waitN(10);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule